// File: doc/BRIEF.md
# Command Port and Interrupt Status Controller

This block is the host-side control core of a network adapter. The host drives every control action through one 16-bit command word. The upper five bits of the word carry an opcode and the lower eleven bits carry an argument. From that word the block selects the active register window, loads two event masks, acknowledges pending events, raises a software interrupt, and gates the receiver and the transmitter. It also issues one-cycle reset strobes to the global, receive and transmit sub-units, and issues a receive-discard strobe.

Event pulses come in from the transmit, receive, statistics and bus-master logic. A pulse becomes a sticky pending bit only if its bit in the indication mask is set. A second mask, the interrupt mask, chooses which pending bits may raise the interrupt line. An interrupt latch is set when an interrupt-enabled bit becomes newly pending, and the host clears it by acknowledge. Reset and discard commands make the block busy for a fixed period. A command written while the block is busy is dropped.

Top module: `nic_cmd_ctrl`

## Requirements
- R1: A command word carries its opcode in bits 15:11 and its argument in bits 10:0. Opcodes 2, 6, 7 and 16 to 31 change no output.
- R2: Opcode 1 loads the window from argument bits 2:0 one cycle after the write. Status bits 15:13 always show the current window.
- R3: The status word has this layout: bit 0 is the latch; bits 8:1 are the pending events (1 host error, 2 tx complete, 3 tx available, 4 rx complete, 5 rx early, 6 interrupt requested, 7 update statistics, 8 bus-master transfer done); bit 11 follows the bus-master-busy input; bit 12 is command busy; bits 10:9 read zero.
- R4: An event input bit k (k = 1 to 5, 7 or 8) that is high at a clock edge sets pending bit k, but only if indication-mask bit k is set. Event input bits 0 and 6 are ignored. Pending bits stay set until they are acknowledged.
- R5: Opcode 15 loads the indication mask from argument bits 8:1. Opcode 14 loads the interrupt mask from argument bits 8:1. A mask loaded at an edge applies to events from the next edge on.
- R6: The latch sets at the edge where a pending bit goes from 0 to 1 while its interrupt-mask bit is set. The interrupt output is the latch ANDed with the OR of (pending AND interrupt mask).
- R7: Opcode 13 clears every status bit 8:0 that is set in the argument; bit 0 of the argument clears the latch. If an event arrives in the same cycle as an acknowledge of its bit, the event wins: the bit stays set, and the latch sets again if that bit is interrupt-enabled.
- R8: Opcode 12 sets pending bit 6, subject to indication-mask bit 6.
- R9: Opcodes 0, 5 and 11 drive argument bits 7:0 for one cycle on the global, receive and transmit reset outputs, respectively. Opcode 8 pulses the discard output for one cycle.
- R10: Opcode 3 clears the receive enable and opcode 4 sets it. Opcode 10 clears the transmit enable and opcode 9 sets it.
- R11: Opcodes 0, 5, 8 and 11 set status bit 12 for exactly 8 cycles, starting the cycle after the write. A command written while bit 12 is set has no effect.
- R12: Opcode 0 also sets the window to 0, clears both masks, all pending bits and the latch, and disables receive and transmit. Events that arrive in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_data_i | input | 16 | Command word: opcode and argument |
| evt_i | input | 9 | Event pulses, aligned to status bit positions |
| bm_busy_i | input | 1 | Bus-master busy level |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt request |
| window_o | output | 3 | Selected register window |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| glb_rst_o | output | 8 | Global reset sub-unit strobes |
| rx_rst_o | output | 8 | Receive reset sub-unit strobes |
| tx_rst_o | output | 8 | Transmit reset sub-unit strobes |
| rx_discard_o | output | 1 | Receive discard strobe |

## Verification
Two actions can land in the same cycle. The first is an acknowledge and a fresh event on the same status bit: the bench issues an acknowledge of the rx-complete bit while the rx-complete event is high in that cycle. It then checks that the bit survives, that the latch sets again, and that the interrupt line stays up. The second is a command that arrives inside the busy window behind a reset or discard command: a window select issued there must leave the window unchanged. A behavioural model advances every cycle, both in the directed scenarios and in a long pseudo-random stream that mixes commands and events, and every output is compared against it each cycle.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int CMD_W  = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = 11;
  localparam int STAT_W = 9;   // latch + events 8:1
  localparam int SUB_W  = 8;
  localparam int WIN_W  = 3;

  localparam logic [OP_W-1:0] OP_GLB_RST = 5'd0;
  localparam logic [OP_W-1:0] OP_WIN_SEL = 5'd1;
  localparam logic [OP_W-1:0] OP_RX_OFF  = 5'd3;
  localparam logic [OP_W-1:0] OP_RX_ON   = 5'd4;
  localparam logic [OP_W-1:0] OP_RX_RST  = 5'd5;
  localparam logic [OP_W-1:0] OP_RX_DISC = 5'd8;
  localparam logic [OP_W-1:0] OP_TX_ON   = 5'd9;
  localparam logic [OP_W-1:0] OP_TX_OFF  = 5'd10;
  localparam logic [OP_W-1:0] OP_TX_RST  = 5'd11;
  localparam logic [OP_W-1:0] OP_SW_REQ  = 5'd12;
  localparam logic [OP_W-1:0] OP_ACK     = 5'd13;
  localparam logic [OP_W-1:0] OP_IE_LD   = 5'd14;
  localparam logic [OP_W-1:0] OP_IND_LD  = 5'd15;

  // hardware-sourced event positions; bit 6 is software only
  localparam logic [STAT_W-1:0] HW_EVT_MASK = 9'h1BE;
  localparam int SW_EVT_BIT = 6;
endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
  import nic_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] data_i,
  output logic             acc_o,
  output logic [OP_W-1:0]  op_o,
  output logic [ARG_W-1:0] arg_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign op_o   = data_i[CMD_W-1 -: OP_W];
  assign arg_o  = data_i[ARG_W-1:0];
  assign busy_o = (cnt_q != '0);
  assign acc_o  = we_i & ~busy_o;

  always_comb begin
    start = 1'b0;
    if (acc_o) begin
      unique case (op_o)
        OP_GLB_RST, OP_RX_RST, OP_TX_RST, OP_RX_DISC: start = 1'b1;
        default: start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (start)     cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (busy_o)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/nic_evt_status.sv
module nic_evt_status
  import nic_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic [STAT_W-1:0] evt_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [STAT_W-1:1] pend_q, ie_q, ind_q;
  logic              latch_q;
  logic [STAT_W-1:0] ack_m;
  logic [STAT_W-1:1] sw_ev, new_ev, keep, rise;
  logic              glb;

  assign glb   = acc_i && (op_i == OP_GLB_RST);
  assign ack_m = (acc_i && (op_i == OP_ACK)) ? arg_i[STAT_W-1:0] : '0;

  always_comb begin
    sw_ev = '0;
    sw_ev[SW_EVT_BIT] = acc_i && (op_i == OP_SW_REQ);
  end

  assign new_ev = ((evt_i[STAT_W-1:1] & HW_EVT_MASK[STAT_W-1:1]) | sw_ev) & ind_q;
  assign keep   = pend_q & ~ack_m[STAT_W-1:1];
  assign rise   = new_ev & ~keep & ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      ie_q    <= '0;
      ind_q   <= '0;
      latch_q <= 1'b0;
    end else if (glb) begin
      pend_q  <= '0;
      ie_q    <= '0;
      ind_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      pend_q  <= keep | new_ev;
      latch_q <= (latch_q & ~ack_m[0]) | (|rise);
      if (acc_i && op_i == OP_IE_LD)  ie_q  <= arg_i[STAT_W-1:1];
      if (acc_i && op_i == OP_IND_LD) ind_q <= arg_i[STAT_W-1:1];
    end
  end

  assign stat_o = {pend_q, latch_q};
  assign irq_o  = latch_q & (|(pend_q & ie_q));
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
  import nic_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [ARG_W-1:0] arg_i,
  output logic [WIN_W-1:0] window_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic [SUB_W-1:0] glb_rst_o,
  output logic [SUB_W-1:0] rx_rst_o,
  output logic [SUB_W-1:0] tx_rst_o,
  output logic             rx_discard_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      window_o     <= '0;
      rx_en_o      <= 1'b0;
      tx_en_o      <= 1'b0;
      glb_rst_o    <= '0;
      rx_rst_o     <= '0;
      tx_rst_o     <= '0;
      rx_discard_o <= 1'b0;
    end else begin
      glb_rst_o    <= '0;
      rx_rst_o     <= '0;
      tx_rst_o     <= '0;
      rx_discard_o <= 1'b0;
      if (acc_i) begin
        unique case (op_i)
          OP_GLB_RST: begin
            glb_rst_o <= arg_i[SUB_W-1:0];
            window_o  <= '0;
            rx_en_o   <= 1'b0;
            tx_en_o   <= 1'b0;
          end
          OP_WIN_SEL: window_o     <= arg_i[WIN_W-1:0];
          OP_RX_OFF:  rx_en_o      <= 1'b0;
          OP_RX_ON:   rx_en_o      <= 1'b1;
          OP_RX_RST:  rx_rst_o     <= arg_i[SUB_W-1:0];
          OP_RX_DISC: rx_discard_o <= 1'b1;
          OP_TX_ON:   tx_en_o      <= 1'b1;
          OP_TX_OFF:  tx_en_o      <= 1'b0;
          OP_TX_RST:  tx_rst_o     <= arg_i[SUB_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_data_i,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              bm_busy_i,
  output logic [CMD_W-1:0]  status_o,
  output logic              irq_o,
  output logic [WIN_W-1:0]  window_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic [SUB_W-1:0]  glb_rst_o,
  output logic [SUB_W-1:0]  rx_rst_o,
  output logic [SUB_W-1:0]  tx_rst_o,
  output logic              rx_discard_o
);
  logic             acc, busy;
  logic [OP_W-1:0]  op;
  logic [ARG_W-1:0] arg;
  logic [STAT_W-1:0] stat;

  nic_cmd_decode #(.BUSY_CYCLES(BUSY_CYCLES)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cmd_we_i), .data_i(cmd_data_i),
    .acc_o(acc), .op_o(op), .arg_o(arg), .busy_o(busy)
  );

  nic_evt_status u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .op_i(op), .arg_i(arg),
    .evt_i(evt_i), .stat_o(stat), .irq_o(irq_o)
  );

  nic_ctl_regs u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .op_i(op), .arg_i(arg),
    .window_o(window_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o),
    .glb_rst_o(glb_rst_o), .rx_rst_o(rx_rst_o), .tx_rst_o(tx_rst_o),
    .rx_discard_o(rx_discard_o)
  );

  assign status_o = {window_o, busy, bm_busy_i, 2'b00, stat};
endmodule

// File: rtl/nic_cmd_ctrl_chk.sv
module nic_cmd_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [15:0] cmd_data_i,
  input logic [8:0]  evt_i,
  input logic [15:0] status_o,
  input logic        irq_o,
  input logic [2:0]  window_o,
  input logic        rx_en_o,
  input logic        tx_en_o,
  input logic [7:0]  rx_rst_o
);
  logic acc;
  assign acc = cmd_we_i && !status_o[12];

  assert_busy_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && status_o[12] && cmd_data_i[15:11] == 5'd1) |=> $stable(window_o));

  assert_irq_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[0]);

  assert_ack_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_data_i[15:11] == 5'd13 && cmd_data_i[0] && evt_i == 9'd0) |=> !status_o[0]);

  assert_win_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_data_i[15:11] == 5'd1) |=> window_o == $past(cmd_data_i[2:0]));

  assert_glb_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_data_i[15:11] == 5'd0) |=>
      (window_o == 3'd0 && !rx_en_o && !tx_en_o && status_o[8:0] == 9'd0 && !irq_o));

  assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rst_o != 8'd0) |=> (rx_rst_o == 8'd0));

  assert_busy_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_data_i[15:11] == 5'd5) |=> status_o[12]);
endmodule

bind nic_cmd_ctrl nic_cmd_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_data_i(cmd_data_i),
  .evt_i(evt_i), .status_o(status_o), .irq_o(irq_o), .window_o(window_o),
  .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .rx_rst_o(rx_rst_o)
);

// File: tb/nic_cmd_ctrl_bench.sv
module nic_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] data = '0;
  logic [8:0]  evt = '0;
  logic        bm = 1'b0;
  logic [15:0] status;
  logic        irq, rx_en, tx_en, disc;
  logic [2:0]  win;
  logic [7:0]  grst, rrst, trst;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R3";
  bit done = 0;

  always #5 clk = ~clk;

  nic_cmd_ctrl u_nic_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_data_i(data),
    .evt_i(evt), .bm_busy_i(bm), .status_o(status), .irq_o(irq),
    .window_o(win), .rx_en_o(rx_en), .tx_en_o(tx_en), .glb_rst_o(grst),
    .rx_rst_o(rrst), .tx_rst_o(trst), .rx_discard_o(disc)
  );

  // behavioural reference model
  int m_win, m_cnt, m_pend, m_latch, m_ie, m_ind, m_rx, m_tx;
  int m_grs, m_rrs, m_trs, m_dsc;
  int op, arg, nev, keep, rise, ackm;
  bit acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_cnt = 0; m_pend = 0; m_latch = 0; m_ie = 0; m_ind = 0;
      m_rx = 0; m_tx = 0; m_grs = 0; m_rrs = 0; m_trs = 0; m_dsc = 0;
    end else begin
      acc = we && (m_cnt == 0);
      op  = (data >> 11) & 31;
      arg = data & 'h7FF;
      m_grs = 0; m_rrs = 0; m_trs = 0; m_dsc = 0;
      nev = evt & 'h1BE;
      if (acc && op == 12) nev = nev | 'h40;
      nev = nev & m_ind;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (acc && op == 0) begin
        m_win = 0; m_pend = 0; m_latch = 0; m_ie = 0; m_ind = 0;
        m_rx = 0; m_tx = 0; m_grs = arg & 'hFF; m_cnt = 8;
      end else begin
        ackm = (acc && op == 13) ? (arg & 'h1FF) : 0;
        keep = m_pend & ~ackm;
        rise = nev & ~keep & m_ie;
        m_pend = (keep | nev) & 'h1FE;
        if (ackm & 1) m_latch = 0;
        if (rise != 0) m_latch = 1;
        if (acc) begin
          case (op)
            1:  m_win = arg & 7;
            3:  m_rx = 0;
            4:  m_rx = 1;
            5:  begin m_rrs = arg & 'hFF; m_cnt = 8; end
            8:  begin m_dsc = 1; m_cnt = 8; end
            9:  m_tx = 1;
            10: m_tx = 0;
            11: begin m_trs = arg & 'hFF; m_cnt = 8; end
            14: m_ie = arg & 'h1FE;
            15: m_ind = arg & 'h1FE;
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] act=%h exp=%h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  // compare every cycle, after inputs settle
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("status R3", int'(status),
            (m_win << 13) | ((m_cnt != 0) << 12) | (int'(bm) << 11) | m_pend | m_latch);
      check("irq R6", int'(irq), int'(m_latch != 0 && (m_pend & m_ie) != 0));
      check("window R2", int'(win), m_win);
      check("rx_en R10", int'(rx_en), m_rx);
      check("tx_en R10", int'(tx_en), m_tx);
      check("glb_rst R9", int'(grst), m_grs);
      check("rx_rst R9", int'(rrst), m_rrs);
      check("tx_rst R9", int'(trst), m_trs);
      check("discard R9", int'(disc), m_dsc);
    end
  end

  task automatic cmd(int o, int a);
    @(negedge clk);
    we = 1'b1; data = 16'((o << 11) | (a & 'h7FF));
    @(negedge clk);
    we = 1'b0; data = '0;
  endtask

  task automatic pulse(int e);
    @(negedge clk);
    evt = 9'(e);
    @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int unsigned lfsr = 32'h1ACE_B00C;
  function automatic int unsigned nxt();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    phase = "R3"; idle(2);
    bm = 1'b1; idle(2); bm = 1'b0;

    phase = "R2"; cmd(1, 5); idle(1); cmd(1, 'h7FA); idle(1);

    phase = "R1"; cmd(2, 'h7FF); cmd(7, 'h1FE); cmd(31, 'h7FF); cmd(16, 3); idle(1);

    phase = "R4"; pulse('h1FF); idle(1);                 // masks empty: ignored
    phase = "R5"; cmd(15, 'h1FA); cmd(14, 'h010);        // bit 2 hidden
    phase = "R4"; pulse('h1FF); idle(1);
    phase = "R7"; cmd(13, 'h1FF); idle(1);

    phase = "R6"; cmd(15, 'h1FE); pulse('h008); idle(1); // tx avail, not irq-enabled
    pulse('h010); idle(2);                               // rx complete raises latch
    phase = "R7";
    @(negedge clk); we = 1; data = 16'((13 << 11) | 'h011); evt = 9'h010;
    @(negedge clk); we = 0; data = 0; evt = 0;
    idle(1);
    cmd(13, 'h011); idle(1);
    cmd(13, 'h001); idle(1);

    phase = "R8"; cmd(14, 'h040); cmd(12, 0); idle(1); cmd(13, 'h041);
    cmd(15, 'h1BE); cmd(12, 0); idle(1);

    phase = "R10"; cmd(4, 0); cmd(9, 0); cmd(3, 0); cmd(10, 0); cmd(9, 0);

    phase = "R11"; cmd(5, 'h0A5); cmd(1, 6); cmd(4, 0); idle(8); cmd(1, 6);
    phase = "R9"; cmd(11, 'h7C3); idle(9); cmd(8, 0); idle(9);

    phase = "R12"; cmd(15, 'h1FE); cmd(14, 'h1FE); cmd(4, 0); pulse('h0BE);
    @(negedge clk); we = 1; data = 16'('h0FF); evt = 9'h1FE;
    @(negedge clk); we = 0; data = 0; evt = 0;
    idle(9); pulse('h1FE); idle(2);

    phase = "RAND";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      int o;
      @(negedge clk);
      r = nxt();
      evt = ((r & 3) == 0) ? 9'(r >> 3) : 9'd0;
      bm  = r[30];
      if (((r >> 12) & 3) == 0) begin
        o = int'((r >> 14) & 15);
        if (o == 0 && ((r >> 20) & 7) != 0) o = 13;
        if (((r >> 24) & 31) == 0) o = 15;
        we = 1'b1; data = 16'((o << 11) | ((r >> 2) & 'h7FF));
      end else begin
        we = 1'b0; data = '0;
      end
    end
    @(negedge clk); we = 0; evt = 0; bm = 0;
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule